// File: doc/BRIEF.md
# Programmable Divider Square-Wave Timer

An 8-bit timer that produces a square wave by dividing a prescaled clock. One of eight prescaler tap inputs is picked by a field in the control register. Each tick of that tap advances an internal counter. When the counter reaches the compare value, the counter returns to zero, the output flip-flop inverts and a one-cycle match pulse is raised. The pin therefore changes level every N ticks, and one full output cycle takes 2N ticks.

Software first writes the configuration with the run bit clear, then writes it again with the run bit set. The compare register has no shadow copy, so a new value takes part in the very next comparison. Stopping the timer holds the pin at its present level and clears the counter. While the timer is stopped, the level bit of the control register drives the pin directly. While it runs, writes to that bit are dropped.

Top module: `pdo_timer`

## Requirements
- R1: After reset, `ctrl_o` reads 0x00, `cmp_o` reads 0x00, `pdo_o` is low and `match_o` is low.
- R2: The control byte is laid out as bit 7 = output level, bits 6:4 = tap select, bit 3 = run, bits 2:0 = mode. Counting takes place only when run is 1 and mode is 3'b001. Any other mode leaves `pdo_o` and `match_o` unchanged. `ctrl_o` returns bits 6:0 as written, with the flip-flop level in bit 7.
- R3: While counting, the counter moves only on cycles where `presc_tick_i[sel]` is high. The selected tap alone sets the rate.
- R4: With compare value N (1..255), `pdo_o` inverts once every N ticks of the selected tap.
- R5: A compare value of 0 divides by 256.
- R6: A write to `cmp_o` through `wr_cmp_i` is used by the comparison one cycle later, even while counting. A write made at a toggle with new value M gives the next toggle M ticks after the previous one.
- R7: Clearing run holds `pdo_o` at its present level and resets the counter to zero. After a restart, the first toggle comes N ticks after run takes effect.
- R8: A control write made while stopped loads bit 7 into the output flip-flop on the next clock.
- R9: A control write made while running leaves the output flip-flop as it was.
- R10: `match_o` is high for exactly the cycles in which `pdo_o` toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_tick_i | input | 8 | Prescaler tap enables, one per divided clock |
| wr_ctrl_i | input | 1 | Write strobe for the control register |
| wr_cmp_i | input | 1 | Write strobe for the compare register |
| wdata_i | input | 8 | Write data |
| ctrl_o | output | 8 | Control readback, with the flip-flop level in bit 7 |
| cmp_o | output | 8 | Compare register readback |
| pdo_o | output | 1 | Divider output (square wave) |
| match_o | output | 1 | One-cycle pulse on each count match |

## Verification
The bench measures half periods for several tap and compare pairs, including the smallest divisor of 1 and the divide-by-256 case for 0. A design that compared against 0 literally would never toggle. A design that counted one tick too many or too few would give a period off by one tick.

A compare write made at a toggle must shorten the very next half period. A buffered compare register would instead keep the old length for one more half period. Restarting after a stop checks that the counter was cleared, since a design that kept a stale count would toggle early.

Level writes are tried both while stopped and while running, to catch a flip-flop that ignores software or one that glitches the running waveform. An unsupported mode with run set must stay silent. Match pulses are counted against output edges.

// File: rtl/pdo_pkg.sv
package pdo_pkg;
  localparam int unsigned TAPS   = 8;
  localparam int unsigned SEL_W  = $clog2(TAPS);
  localparam logic [2:0]  MODE_DIV = 3'b001;

  typedef struct packed {
    logic             lvl;
    logic [SEL_W-1:0] sel;
    logic             run;
    logic [2:0]       mode;
  } ctrl_t;
endpackage

// File: rtl/pdo_tick_sel.sv
module pdo_tick_sel #(
  parameter int unsigned TAPS  = 8,
  parameter int unsigned SEL_W = $clog2(TAPS)
) (
  input  logic [TAPS-1:0]  tap_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  always_comb tick_o = tap_i[sel_i];
endmodule

// File: rtl/pdo_counter.sv
module pdo_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             hit_o,
  output logic             match_o
);
  localparam int unsigned LIM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [LIM_W-1:0] limit, nxt;

  // zero compare means a full 2^CNT_W division
  always_comb begin
    limit = (cmp_i == '0) ? (LIM_W'(1) << CNT_W) : {1'b0, cmp_i};
    nxt   = {1'b0, cnt_q} + LIM_W'(1);
    hit_o = en_i && tick_i && (nxt == limit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= hit_o;
      if (!en_i)       cnt_q <= '0;
      else if (hit_o)  cnt_q <= '0;
      else if (tick_i) cnt_q <= nxt[CNT_W-1:0];
    end
  end

  logic match_q;
  assign match_o = match_q;

  p_idle_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
  p_match_needs_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(en_i));
endmodule

// File: rtl/pdo_out_ff.sv
module pdo_out_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic load_val_i,
  input  logic toggle_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= 1'b0;
    else if (load_i)   q_o <= load_val_i;
    else if (toggle_i) q_o <= ~q_o;
  end
endmodule

// File: rtl/pdo_timer.sv
module pdo_timer
  import pdo_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAPS-1:0]  presc_tick_i,
  input  logic             wr_ctrl_i,
  input  logic             wr_cmp_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       ctrl_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             pdo_o,
  output logic             match_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cmp_q;
  logic             tick, hit, en, ff_load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl_i) ctrl_q <= ctrl_t'(wdata_i);
      if (wr_cmp_i)  cmp_q  <= wdata_i[CNT_W-1:0];
    end
  end

  assign en      = ctrl_q.run && (ctrl_q.mode == MODE_DIV);
  // level bit only reaches the flip-flop while stopped
  assign ff_load = wr_ctrl_i && !ctrl_q.run;

  pdo_tick_sel #(.TAPS(TAPS), .SEL_W(SEL_W)) u_sel (
    .tap_i (presc_tick_i),
    .sel_i (ctrl_q.sel),
    .tick_o(tick)
  );

  pdo_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .tick_i (tick),
    .cmp_i  (cmp_q),
    .hit_o  (hit),
    .match_o(match_o)
  );

  pdo_out_ff u_ff (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ff_load),
    .load_val_i(wdata_i[7]),
    .toggle_i  (hit),
    .q_o       (pdo_o)
  );

  assign ctrl_o = {pdo_o, ctrl_q.sel, ctrl_q.run, ctrl_q.mode};
  assign cmp_o  = cmp_q;

  p_frozen_when_stopped_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.run && !wr_ctrl_i) |=> $stable(pdo_o));
  p_stopped_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.run && wr_ctrl_i) |=> (pdo_o == $past(wdata_i[7])));
  p_toggle_is_match_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.run |=> ((pdo_o ^ $past(pdo_o)) == match_o));
endmodule

// File: tb/tb_pdo_timer.sv
module tb_pdo_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] presc;
  logic       wr_ctrl = 1'b0, wr_cmp = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] ctrl_rd, cmp_rd;
  logic       pdo, match;
  int         n_chk = 0, n_bad = 0;
  logic [15:0] ph = '0;
  bit         done = 0;

  always #5 clk = ~clk;

  pdo_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .presc_tick_i(presc),
    .wr_ctrl_i(wr_ctrl), .wr_cmp_i(wr_cmp), .wdata_i(wdata),
    .ctrl_o(ctrl_rd), .cmp_o(cmp_rd), .pdo_o(pdo), .match_o(match)
  );

  // tap k pulses once every 2^k cycles
  always @(negedge clk) ph <= ph + 16'd1;
  always_comb
    for (int k = 0; k < 8; k++) presc[k] = ((ph & ((16'd1 << k) - 16'd1)) == 16'd0);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_c(input logic [7:0] v);
    @(negedge clk); wr_ctrl = 1'b1; wdata = v;
    @(negedge clk); wr_ctrl = 1'b0;
  endtask

  task automatic wr_k(input logic [7:0] v);
    @(negedge clk); wr_cmp = 1'b1; wdata = v;
    @(negedge clk); wr_cmp = 1'b0;
  endtask

  // waits for one edge, then counts cycles to the next
  task automatic measure(output int cyc);
    logic p;
    int g;
    cyc = -1;
    p = pdo; g = 0;
    while (pdo == p && g < 5000) begin @(negedge clk); g++; end
    if (g >= 5000) return;
    p = pdo; cyc = 0;
    while (pdo == p && cyc < 5000) begin @(negedge clk); cyc++; end
  endtask

  // {sel[2:0], cmp[7:0], half period in cycles[11:0]}
  localparam int NV = 6;
  localparam logic [22:0] VEC [NV] = '{
    {3'd0, 8'd1,   12'd1},
    {3'd0, 8'd5,   12'd5},
    {3'd1, 8'd3,   12'd6},
    {3'd2, 8'd4,   12'd16},
    {3'd3, 8'h3D,  12'd488},
    {3'd0, 8'd0,   12'd256}
  };

  initial begin
    int c, m;
    logic p;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ctrl_rd == 8'h00, "R1 ctrl", ctrl_rd, 0);
    check(cmp_rd == 8'h00, "R1 cmp", cmp_rd, 0);
    check(pdo == 1'b0, "R1 pdo", pdo, 0);
    check(match == 1'b0, "R1 match", match, 0);
    rst_n = 1'b1;

    // R3 R4 R5: table of tap/compare pairs
    for (int i = 0; i < NV; i++) begin
      wr_c(8'h01);
      wr_k(VEC[i][19:12]);
      wr_c({1'b0, VEC[i][22:20], 1'b1, 3'b001});
      measure(c);
      check(c == int'(VEC[i][11:0]), $sformatf("R4/R5 vec%0d", i), c, VEC[i][11:0]);
    end

    // R6 compare write at a toggle takes effect at once
    wr_c(8'h01); wr_k(8'd100); wr_c(8'h09);
    measure(c);
    p = pdo; c = 0;
    wr_cmp = 1'b1; wdata = 8'd5;
    while (c < 500) begin
      @(negedge clk); c++; wr_cmp = 1'b0;
      if (pdo != p) break;
    end
    check(c == 5, "R6 immediate compare", c, 5);

    // R10 match pulses line up with edges, cmp 4 -> 10 in 40 cycles
    wr_k(8'd4);
    measure(c);
    m = 0; p = pdo;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (match) m++;
      check(match == (pdo != p), "R10 match vs edge", match, pdo != p);
      p = pdo;
    end
    check(m == 10, "R10 match count", m, 10);

    // R9 level write while running is dropped
    wr_k(8'd50);
    measure(c);
    p = pdo;
    wr_ctrl = 1'b1; wdata = {~p, 7'b0001001};
    @(negedge clk); wr_ctrl = 1'b0;
    for (int i = 0; i < 10; i++) begin
      check(pdo == p, "R9 level ignored", pdo, p);
      @(negedge clk);
    end

    // R7 stop freezes level; make it high first
    wr_k(8'd3);
    measure(c);
    if (pdo == 1'b0) measure(c);
    p = pdo;
    wr_c(8'h01);
    repeat (20) @(negedge clk);
    check(pdo == p, "R7 frozen level", pdo, p);

    // R8 level loads while stopped
    wr_c(8'h81);
    check(pdo == 1'b1, "R8 load high", pdo, 1);
    wr_c(8'h01);
    check(pdo == 1'b0, "R8 load low", pdo, 0);

    // R7 restart: counter cleared, first toggle N+1 cycles after the write
    wr_k(8'd7);
    @(negedge clk);
    p = pdo; c = 0;
    wr_ctrl = 1'b1; wdata = 8'h09;
    while (c < 500) begin
      @(negedge clk); c++; wr_ctrl = 1'b0;
      if (pdo != p) break;
    end
    check(c == 8, "R7 restart from zero", c, 8);

    // R2 other mode with run set stays silent; readback layout
    wr_c(8'h00);
    wr_k(8'd3);
    wr_c(8'h08);
    check(ctrl_rd == 8'h08, "R2 readback", ctrl_rd, 8);
    m = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (match || pdo) m++;
    end
    check(m == 0, "R2 no count in other mode", m, 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule